// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a small byte-wide nonvolatile memory. An SPI host (clock idle low or idle high, data sampled on the rising clock edge) selects it with an active-low select. The host shifts in an instruction byte, an address and write data, and shifts out array contents or a status byte. The controller runs on a fast system clock. It oversamples the serial pins through two-flop synchronizers and acts on the clock edges it detects there. The memory array sits outside the block behind a simple synchronous RAM port with one cycle of read latency.

A write is collected into a one-page staging buffer first. It reaches the array only if the host deselects the part exactly on a byte boundary after at least one data byte. The controller then holds a busy interval of a programmable number of system clocks, in which it copies the staged bytes into the RAM. A status write follows the same commit rule. Write enable, block protection of the array and a hardware lock on status writes guard against stray writes. A pause input can freeze a transfer in the middle of a bit sequence.

Top module: `spi_mem_slave`

## Requirements
- R1: Six instructions are decoded, sent MSB first and sampled on rising SCK: 0x06 enable writes, 0x04 disable writes, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array. The address is two bytes, MSB first.
- R2: `spi_miso` changes only after a falling SCK edge during a read. `spi_miso_oe` is low out of reset and goes low whenever select is high.
- R3: A read uses the low 11 address bits. It streams bytes from consecutive addresses and wraps from 0x7FF to 0x000 until select rises.
- R4: A write takes 1 to 32 data bytes. Bytes past the end of the 32-byte page wrap to the start of that same page and overwrite earlier bytes.
- R5: An array or status write commits only if select rises right after bit 0 of a data byte, with at least one data byte received. Otherwise nothing changes and write enable keeps its value.
- R6: Write enable is set only when select rises directly after the 8 bits of 0x06. Any further clock in that selection cancels it. 0x04 clears it. A write or status write issued while it is clear is ignored.
- R7: Write enable clears at reset and when any write commits. A commit starts a busy interval of BUSY system clocks.
- R8: With select low, a low `pause_n` taken while SCK is low freezes the bit position. SCK edges are ignored until `pause_n` returns high with SCK low, and the transfer then continues from the same bit.
- R9: After reset no instruction is accepted until select has been seen going from high to low.
- R10: Status byte: bit 7 lock enable, bits 3:2 protect level, bit 1 write enable, bit 0 busy, other bits 0. While busy, every bit reads 1.
- R11: Protect level 1 guards 0x600 to 0x7FF, level 2 guards 0x400 to 0x7FF, level 3 guards the whole array. A write to a guarded page is dropped and write enable stays set.
- R12: A status write is dropped, leaving write enable set, while the lock bit is 1 and `wprot_n` is low.
- R13: While busy, every instruction except 0x05 is ignored. An unknown opcode is ignored. In both cases the rest of the selection is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| pause_n | input | 1 | Active-low transfer pause |
| wprot_n | input | 1 | Active-low hardware lock for status writes |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (pad is high impedance when low) |
| mem_addr | output | AW | RAM address, shared by reads and writes |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one clock after the address |

## Verification
Each pin reaches the controller three system clocks after it changes: two synchronizer flops plus the edge register. A read bit therefore settles on `spi_miso` about four clocks after a falling SCK. The bench holds each SCK phase for six clocks and samples just before the next rising edge. A commit starts the busy interval about three clocks after select rises, and the staged bytes reach the RAM within the first page-length plus one clocks of that interval. The bench therefore reads status at once to see the all-ones busy byte, and waits longer than the busy interval before it reads the array back. The expected bytes come from the bench's own array model and are queued before each transfer. A monitor compares them in order as the serial bytes are captured.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    S_OPC, S_ADDR, S_RDAT, S_RSTAT, S_WDAT, S_WSTAT, S_WEN, S_SKIP
  } ph_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/spi_wr_engine.sv
module spi_wr_engine #(
  parameter int AW = 11,
  parameter int PAGE = 32,
  parameter int BUSY = 64,
  localparam int CW = $clog2(PAGE),
  localparam int PW = AW - CW,
  localparam int BW = $clog2(BUSY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          buf_clr,
  input  logic          buf_we,
  input  logic [CW-1:0] buf_col,
  input  logic [7:0]    buf_din,
  input  logic          start,
  input  logic          start_arr,
  input  logic [PW-1:0] page,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  // BUSY must exceed PAGE + 1 so the drain ends inside the busy interval.
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] vld;
  logic [PW-1:0]   page_q;
  logic [BW-1:0]   cnt;
  logic [CW:0]     idx;
  logic            arr_q;

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_col] <= buf_din;
    wr_data <= pbuf[idx[CW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0; page_q <= '0; cnt <= '0; idx <= '0;
      arr_q <= 1'b0; busy <= 1'b0; mem_we <= 1'b0; wr_addr <= '0;
    end else begin
      if (buf_clr) vld <= '0;
      else if (buf_we) vld[buf_col] <= 1'b1;
      if (start) begin
        busy <= 1'b1; cnt <= BW'(BUSY - 1); idx <= '0;
        arr_q <= start_arr; page_q <= page;
      end else if (busy) begin
        if (!idx[CW]) idx <= idx + 1'b1;
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
      mem_we  <= busy & arr_q & ~idx[CW] & vld[idx[CW-1:0]];
      wr_addr <= {page_q, idx[CW-1:0]};
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW = 11,
  parameter int PAGE = 32,
  parameter int BUSY = 64,
  localparam int CW = $clog2(PAGE),
  localparam int PW = AW - CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          pause_n,
  input  logic          wprot_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  import spi_mem_pkg::*;

  logic [4:0] lvl;
  // select resets low so a select held low through reset is not an edge
  spi_pin_sync #(.W(5), .STAGES(2), .RST_VAL(5'b11000)) u_sync (
    .clk(clk), .rst(rst),
    .din({wprot_n, pause_n, spi_cs_n, spi_mosi, spi_sck}), .lvl(lvl));

  logic sck_s, si_s, cs_hi, pause_s, wp_lo;
  assign sck_s = lvl[0];
  assign si_s = lvl[1];
  assign cs_hi = lvl[2];
  assign pause_s = ~lvl[3];
  assign wp_lo = ~lvl[4];

  logic sck_q, cs_q, hold_act, armed, busy, wel, lock_en, ws_lock, got, is_rd;
  logic adr_first, fetch, fetch_d, first, so_q, oe_q;
  logic [1:0] bp, ws_bp;
  logic [2:0] bit_cnt, tx_cnt;
  logic [6:0] sh;
  logic [7:0] tx, nxt, status;
  logic [AW-9:0] adr_hi;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [CW-1:0] col;
  logic [PW-1:0] wpage;
  ph_t ph;

  logic sck_r, sck_f, cs_rise, cs_fall, active, shift_en, out_en;
  logic [7:0] in_byte;
  logic [AW-1:0] addr_full;
  logic cmt_arr, cmt_st;

  function automatic logic blk_locked(input logic [1:0] lvl_sel, input logic [1:0] top2);
    case (lvl_sel)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  assign sck_r = sck_s & ~sck_q;
  assign sck_f = ~sck_s & sck_q;
  assign cs_rise = cs_hi & ~cs_q;
  assign cs_fall = ~cs_hi & cs_q;
  assign active = armed & ~cs_hi & ~hold_act;
  assign shift_en = active & sck_r;
  assign out_en = active & sck_f;
  assign in_byte = {sh, si_s};
  assign addr_full = {adr_hi, in_byte};
  assign status = busy ? 8'hFF : {lock_en, 3'b000, bp, wel, 1'b0};
  assign cmt_arr = cs_rise & armed & (ph == S_WDAT) & got & (bit_cnt == 3'd0)
                   & ~blk_locked(bp, wpage[PW-1:PW-2]);
  assign cmt_st = cs_rise & armed & (ph == S_WSTAT) & got & (bit_cnt == 3'd0)
                  & ~(lock_en & wp_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0; cs_q <= 1'b0; hold_act <= 1'b0; armed <= 1'b0;
      wel <= 1'b0; lock_en <= 1'b0; bp <= 2'b00; ws_lock <= 1'b0; ws_bp <= 2'b00;
      got <= 1'b0; is_rd <= 1'b0; adr_first <= 1'b0; fetch <= 1'b0; fetch_d <= 1'b0;
      first <= 1'b0; so_q <= 1'b0; oe_q <= 1'b0; bit_cnt <= '0; tx_cnt <= '0;
      sh <= '0; tx <= '0; nxt <= '0; adr_hi <= '0; rd_addr <= '0; col <= '0;
      wpage <= '0; ph <= S_OPC;
    end else begin
      sck_q <= sck_s;
      cs_q <= cs_hi;
      fetch <= 1'b0;
      fetch_d <= fetch;
      if (!sck_s) hold_act <= pause_s;
      if (cs_fall) armed <= 1'b1;
      if (cmt_arr || cmt_st) wel <= 1'b0;
      if (cmt_st) begin lock_en <= ws_lock; bp <= ws_bp; end
      if (cs_rise && armed && ph == S_WEN && bit_cnt == 3'd0) wel <= 1'b1;

      if (cs_hi) begin
        ph <= S_OPC; bit_cnt <= '0; oe_q <= 1'b0; got <= 1'b0;
      end else if (shift_en) begin
        sh <= in_byte[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (ph == S_WEN) ph <= S_SKIP;
        else if (bit_cnt == 3'd7) begin
          case (ph)
            S_OPC: begin
              if (busy && in_byte != OP_RSTAT) ph <= S_SKIP;
              else case (in_byte)
                OP_WEN:   ph <= S_WEN;
                OP_WDIS:  begin wel <= 1'b0; ph <= S_SKIP; end
                OP_RSTAT: begin ph <= S_RSTAT; tx <= status; tx_cnt <= '0; end
                OP_READ:  begin ph <= S_ADDR; is_rd <= 1'b1; adr_first <= 1'b1; end
                OP_WRITE: begin
                  ph <= wel ? S_ADDR : S_SKIP; is_rd <= 1'b0; adr_first <= 1'b1;
                end
                OP_WSTAT: ph <= wel ? S_WSTAT : S_SKIP;
                default:  ph <= S_SKIP;
              endcase
            end
            S_ADDR: begin
              if (adr_first) begin
                adr_hi <= in_byte[AW-9:0]; adr_first <= 1'b0;
              end else if (is_rd) begin
                ph <= S_RDAT; rd_addr <= addr_full; fetch <= 1'b1;
                first <= 1'b1; tx_cnt <= '0;
              end else begin
                ph <= S_WDAT; col <= addr_full[CW-1:0]; wpage <= addr_full[AW-1:CW];
              end
            end
            S_WDAT: begin col <= col + 1'b1; got <= 1'b1; end
            S_WSTAT: begin
              if (got) ph <= S_SKIP;
              else begin got <= 1'b1; ws_lock <= in_byte[7]; ws_bp <= in_byte[3:2]; end
            end
            default: ;
          endcase
        end
      end

      if (out_en && (ph == S_RSTAT || ph == S_RDAT)) begin
        so_q <= tx[7];
        oe_q <= 1'b1;
        tx <= {tx[6:0], 1'b0};
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == 3'd7) begin
          tx <= (ph == S_RSTAT) ? status : nxt;
          if (ph == S_RDAT) begin rd_addr <= rd_addr + 1'b1; fetch <= 1'b1; end
        end
      end

      if (fetch_d) begin
        if (first) begin
          tx <= mem_rdata; first <= 1'b0; rd_addr <= rd_addr + 1'b1; fetch <= 1'b1;
        end else nxt <= mem_rdata;
      end
    end
  end

  spi_wr_engine #(.AW(AW), .PAGE(PAGE), .BUSY(BUSY)) u_wr (
    .clk(clk), .rst(rst),
    .buf_clr(shift_en & (ph == S_ADDR) & (bit_cnt == 3'd7) & ~adr_first & ~is_rd),
    .buf_we(shift_en & (ph == S_WDAT) & (bit_cnt == 3'd7)),
    .buf_col(col), .buf_din(in_byte),
    .start(cmt_arr | cmt_st), .start_arr(cmt_arr), .page(wpage),
    .busy(busy), .mem_we(mem_we), .wr_addr(wr_addr), .wr_data(mem_wdata));

  assign mem_addr = busy ? wr_addr : rd_addr;
  assign spi_miso = so_q;
  assign spi_miso_oe = oe_q;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int AW = 11,
  parameter int PAGE = 32,
  localparam int CW = $clog2(PAGE)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_hi,
  input logic          hold_act,
  input logic          armed,
  input logic          busy,
  input logic          wel,
  input logic [2:0]    bit_cnt,
  input logic          oe,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !oe);

  a_r9_unarmed_silent: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!oe && !busy));

  a_r6_commit_needs_wel: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  a_r7_wel_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);

  a_r4_write_in_page: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr[AW-1:CW] == $past(mem_addr[AW-1:CW]));

  a_r13_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  a_r8_pause_freezes: assert property (@(posedge clk) disable iff (rst)
    (hold_act && !cs_hi) |=> $stable(bit_cnt));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_hi), .hold_act(hold_act), .armed(armed),
  .busy(busy), .wel(wel), .bit_cnt(bit_cnt), .oe(spi_miso_oe),
  .mem_we(mem_we), .mem_addr(mem_addr));

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY = 1500;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, pause_n = 1'b1, wprot_n = 1'b1;
  logic miso, miso_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [DEPTH];
  logic [7:0] refm [DEPTH];

  always #4 clk = ~clk;

  spi_mem_slave #(.AW(AW), .PAGE(32), .BUSY(BUSY)) dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .pause_n(pause_n), .wprot_n(wprot_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] act_q[$];
  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk(a === e.v, e.tag, a, e.v);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i]; tick(HP);
      r[i] = miso; sck = 1'b1; tick(HP); sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic desel();
    tick(HP); cs_n = 1'b1; tick(2 * HP);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    sel(); xbyte(op, r); desel();
  endtask

  task automatic stat_expect(input logic [7:0] ex, input string tag);
    logic [7:0] r;
    exp_q.push_back('{ex, tag});
    sel(); xbyte(8'h05, r); xbyte(8'h00, r); act_q.push_back(r); desel();
  endtask

  task automatic wstat(input logic [7:0] v);
    logic [7:0] r;
    sel(); xbyte(8'h01, r); xbyte(v, r); desel();
  endtask

  task automatic wr_page(input logic [10:0] a, input int n, input logic [7:0] base, input logic ok);
    logic [7:0] r;
    sel(); xbyte(8'h02, r); xbyte({5'b0, a[10:8]}, r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(base + 8'(i), r);
      if (ok) refm[{a[10:5], 5'(a[4:0] + 5'(i))}] = base + 8'(i);
    end
    desel();
  endtask

  task automatic rd_expect(input logic [10:0] a, input int n, input string tag);
    logic [7:0] r;
    for (int i = 0; i < n; i++) exp_q.push_back('{refm[11'(a + 11'(i))], tag});
    sel(); xbyte(8'h03, r); xbyte({5'b0, a[10:8]}, r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin xbyte(8'h00, r); act_q.push_back(r); end
    desel();
  endtask

  task automatic settle();
    tick(BUSY + 100);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < DEPTH; i++) begin ram[i] = 8'h00; refm[i] = 8'h00; end
    tick(10); rst = 1'b0; tick(5);
    chk(miso_oe === 1'b0, "R2 reset output enable", {7'b0, miso_oe}, 8'h00);

    // R9: select low since reset, no falling edge yet -> enable instruction ignored
    xbyte(8'h06, r); desel();
    chk(miso_oe === 1'b0, "R2 deselected output enable", {7'b0, miso_oe}, 8'h00);
    stat_expect(8'h00, "R9 no command before select edge");

    // R6 / R1 write enable handling
    cmd(8'h06); stat_expect(8'h02, "R6 enable set");
    cmd(8'h04); stat_expect(8'h00, "R6 disable clears");
    sel(); xbyte(8'h06, r); xbyte(8'h00, r); desel();
    stat_expect(8'h00, "R6 enable cancelled by extra clocks");
    wr_page(11'h200, 1, 8'h5A, 1'b0); settle();
    rd_expect(11'h200, 1, "R6 write without enable ignored");

    // R4 R7 R10 R13 commit, busy status, busy ignores reads
    cmd(8'h06); wr_page(11'h000, 3, 8'h11, 1'b1);
    stat_expect(8'hFF, "R10 busy status all ones");
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    chk(miso_oe === 1'b0, "R13 read ignored while busy", {7'b0, miso_oe}, 8'h00);
    desel();
    settle();
    stat_expect(8'h00, "R7 enable cleared after commit");
    rd_expect(11'h000, 3, "R3 sequential read");

    // R13 unknown opcode skips rest of selection
    sel(); xbyte(8'hFF, r); xbyte(8'h06, r); desel();
    stat_expect(8'h00, "R13 unknown opcode ignored");

    // R3 wrap across array end
    cmd(8'h06); wr_page(11'h7FE, 2, 8'hA0, 1'b1); settle();
    rd_expect(11'h7FE, 4, "R3 wrap 7FF to 000");

    // R4 page wrap
    cmd(8'h06); wr_page(11'h03E, 4, 8'hB0, 1'b1); settle();
    rd_expect(11'h03E, 2, "R4 page tail");
    rd_expect(11'h020, 2, "R4 wrapped to page start");

    // R5 abort on partial byte
    cmd(8'h06);
    sel(); xbyte(8'h02, r); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'hC3, r);
    xbits(8'hFF, 3, r); desel(); settle();
    stat_expect(8'h02, "R5 enable kept after abort");
    rd_expect(11'h100, 1, "R5 aborted write not stored");

    // R11 R12 protection
    wstat(8'h8C); settle();
    stat_expect(8'h8C, "R10 status fields after status write");
    cmd(8'h06); wr_page(11'h040, 1, 8'h77, 1'b0); settle();
    rd_expect(11'h040, 1, "R11 full protection drops write");
    stat_expect(8'h8E, "R11 enable kept on protected write");
    wprot_n = 1'b0; wstat(8'h00); settle();
    stat_expect(8'h8E, "R12 locked status write dropped");
    wprot_n = 1'b1; wstat(8'h04); settle();
    stat_expect(8'h04, "R12 status write after unlock");
    cmd(8'h06); wr_page(11'h600, 1, 8'h66, 1'b0); settle();
    rd_expect(11'h600, 1, "R11 top quarter protected");
    wr_page(11'h5FF, 1, 8'h55, 1'b1); settle();
    rd_expect(11'h5FF, 2, "R11 below quarter writable");

    // R8 pause in the middle of the address
    exp_q.push_back('{refm[11'h000], "R8 read after pause"});
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbits(8'h00, 4, r);
    mosi = 1'b1; tick(HP); pause_n = 1'b0; tick(HP);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; tick(HP); sck = 1'b0; tick(HP); end
    pause_n = 1'b1; tick(HP);
    xbits(8'h00, 4, r); xbyte(8'h00, r); act_q.push_back(r);
    chk(miso_oe === 1'b1, "R2 output enabled during read", {7'b0, miso_oe}, 8'h01);
    desel();

    tick(20);
    chk(exp_q.size() == 0, "R1 all queued bytes compared", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule